// File: doc/BRIEF.md
# Parity-Protected Quad 4-Point FFT

This block runs four independent 4-point DFTs side by side on real 6-bit samples. A fifth, redundant transform runs on the point-wise sum of the four input vectors. Each of the four working transforms is checked by an energy test. The test compares the sum of squared output magnitudes with four times the sum of squared input samples, using exact integer arithmetic. A mismatch raises that channel's error flag.

When exactly one flag is up, that channel's spectrum is rebuilt. The block takes the redundant transform's output and subtracts the other three spectra from it. This works because the DFT is linear. When two or more flags are up, the spectra leave unchanged and an uncorrectable indicator is raised.

A fault-injection input adds a chosen offset to one output component of selected channels, so the protection path can be exercised. Results appear a fixed two cycles after the input strobe.

Top module: `parity_fft_guard`

## Requirements
- R1: While and right after synchronous reset, `out_valid`, `err_flags`, `uncorrectable` and all output spectra are zero.
- R2: `out_valid` is high exactly two clock edges after a cycle with `in_valid` high, and low otherwise.
- R3: With no fault injected, each channel c outputs its exact 4-point DFT X[k] = sum over n of x[n]·e^(-j2πkn/4) and all flags are low. Input point n of channel c sits at bits (c·4+n)·W. Output bin k of channel c sits at bits (c·4+k)·(W+2) of `out_re`/`out_im`. Both are two's complement.
- R4: The value `inj_value` (signed, W bits) is added to the real part of bin 1 of every channel c whose bit `inj_mask[c]` is 1. The addition is made in the cycle `in_valid` is sampled.
- R5: Bit c of `err_flags` is 1 exactly when channel c's output energy differs from four times its input energy. An odd injected value always causes this.
- R6: When exactly one flag is set, that channel's output equals the fault-free DFT, rebuilt from the parity spectrum. `uncorrectable` stays 0.
- R7: When two or more flags are set, all channels leave with their injected errors intact and `uncorrectable` is 1.
- R8: The parity path is 2 bits wider than the working paths. Full-scale inputs (all −32 or all +31 on every channel) are therefore rebuilt exactly.
- R9: `err_flags` and `uncorrectable` are zero in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vectors valid strobe |
| in_samples | input | NCH·4·W | Four real samples per channel, packed |
| inj_mask | input | NCH | Channels receiving an injected fault |
| inj_value | input | W | Signed offset added to bin 1 real part |
| out_valid | output | 1 | Output spectra valid strobe |
| out_re | output | NCH·4·(W+2) | Real parts of corrected spectra |
| out_im | output | NCH·4·(W+2) | Imaginary parts of corrected spectra |
| err_flags | output | NCH | Per-channel energy-check failure |
| uncorrectable | output | 1 | Two or more channels flagged |

## Verification
Every result of this block (spectra, flags and the uncorrectable indicator) is due on the second rising edge after `in_valid` is sampled. The bench drives each transaction on a falling edge. It samples on the next falling edge to confirm nothing has appeared yet, with the flags quiet, and then on the falling edge after that for the full result. The sweep walks all sixteen injection masks across about a thousand sample patterns and several odd offsets, plus full-scale vectors. Expected spectra come from the closed-form 4-point DFT in the bench.

// File: rtl/pfg_pkg.sv
`timescale 1ns/1ps
package pfg_pkg;
  // The transform core is a fixed radix-2 4-point butterfly pair.
  localparam int NPT = 4;
  // Extra bits a 4-point transform of real data needs over its input.
  localparam int GROW = 2;
endpackage

// File: rtl/pfg_fft4.sv
`timescale 1ns/1ps
// Combinational 4-point DFT of real samples, radix-2 decimation in time.
module pfg_fft4 #(
  parameter int IW = 6,
  localparam int OW = IW + pfg_pkg::GROW
) (
  input  logic [pfg_pkg::NPT*IW-1:0] x_flat,
  output logic [pfg_pkg::NPT*OW-1:0] re_flat,
  output logic [pfg_pkg::NPT*OW-1:0] im_flat
);
  logic signed [IW-1:0] p0, p1, p2, p3;
  logic signed [OW-1:0] ev_sum, ev_dif, od_sum, od_dif;

  always_comb begin
    p0 = signed'(x_flat[0*IW +: IW]);
    p1 = signed'(x_flat[1*IW +: IW]);
    p2 = signed'(x_flat[2*IW +: IW]);
    p3 = signed'(x_flat[3*IW +: IW]);
    ev_sum = OW'(p0) + OW'(p2);
    ev_dif = OW'(p0) - OW'(p2);
    od_sum = OW'(p1) + OW'(p3);
    od_dif = OW'(p1) - OW'(p3);
    re_flat[0*OW +: OW] = ev_sum + od_sum;
    im_flat[0*OW +: OW] = '0;
    re_flat[1*OW +: OW] = ev_dif;
    im_flat[1*OW +: OW] = -od_dif;
    re_flat[2*OW +: OW] = ev_sum - od_sum;
    im_flat[2*OW +: OW] = '0;
    re_flat[3*OW +: OW] = ev_dif;
    im_flat[3*OW +: OW] = od_dif;
  end
endmodule

// File: rtl/pfg_sqsum.sv
`timescale 1ns/1ps
// Sum of squared magnitudes over N complex values (imag may be tied to zero).
module pfg_sqsum #(
  parameter int CW = 8,
  parameter int N  = 4,
  parameter int SW = 20
) (
  input  logic [N*CW-1:0] re_flat,
  input  logic [N*CW-1:0] im_flat,
  output logic [SW-1:0]   energy
);
  logic signed [CW-1:0] rv, iv;
  logic signed [SW-1:0] rx, ix;

  always_comb begin
    energy = '0;
    rv = '0; iv = '0; rx = '0; ix = '0;
    for (int k = 0; k < N; k++) begin
      rv = signed'(re_flat[k*CW +: CW]);
      iv = signed'(im_flat[k*CW +: CW]);
      rx = SW'(rv);
      ix = SW'(iv);
      energy = energy + SW'(rx * rx) + SW'(ix * ix);
    end
  end
endmodule

// File: rtl/pfg_rebuild.sv
`timescale 1ns/1ps
// Replaces a single flagged spectrum by parity minus the other spectra.
module pfg_rebuild #(
  parameter int NCH = 4,
  parameter int N   = 4,
  parameter int OW  = 8,
  parameter int PW  = 10
) (
  input  logic [NCH*N*OW-1:0] ch_re,
  input  logic [NCH*N*OW-1:0] ch_im,
  input  logic [N*PW-1:0]     par_re,
  input  logic [N*PW-1:0]     par_im,
  input  logic [NCH-1:0]      flags,
  output logic [NCH*N*OW-1:0] fix_re,
  output logic [NCH*N*OW-1:0] fix_im,
  output logic                multi
);
  logic                 single;
  logic signed [PW-1:0] acc_r, acc_i;

  always_comb begin
    single = $onehot(flags);
    multi  = ($countones(flags) > 1);
    fix_re = ch_re;
    fix_im = ch_im;
    acc_r  = '0;
    acc_i  = '0;
    for (int c = 0; c < NCH; c++) begin
      if (single && flags[c]) begin
        for (int k = 0; k < N; k++) begin
          acc_r = signed'(par_re[k*PW +: PW]);
          acc_i = signed'(par_im[k*PW +: PW]);
          for (int o = 0; o < NCH; o++) begin
            if (o != c) begin
              acc_r = acc_r - PW'(signed'(ch_re[(o*N+k)*OW +: OW]));
              acc_i = acc_i - PW'(signed'(ch_im[(o*N+k)*OW +: OW]));
            end
          end
          fix_re[(c*N+k)*OW +: OW] = OW'(acc_r);
          fix_im[(c*N+k)*OW +: OW] = OW'(acc_i);
        end
      end
    end
  end
endmodule

// File: rtl/parity_fft_guard.sv
`timescale 1ns/1ps
module parity_fft_guard #(
  parameter int NCH = 4,
  parameter int W   = 6,
  localparam int N  = pfg_pkg::NPT,
  localparam int OW = W + pfg_pkg::GROW,
  localparam int SW_IN = W + 2,
  localparam int PW = SW_IN + pfg_pkg::GROW,
  localparam int SW = 2*OW + 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [NCH*N*W-1:0]  in_samples,
  input  logic [NCH-1:0]      inj_mask,
  input  logic [W-1:0]        inj_value,
  output logic                out_valid,
  output logic [NCH*N*OW-1:0] out_re,
  output logic [NCH*N*OW-1:0] out_im,
  output logic [NCH-1:0]      err_flags,
  output logic                uncorrectable
);
  // ---------------- stage 1: transforms and input energy ----------------
  logic [NCH*N*OW-1:0] raw_re, raw_im, hit_re;
  logic [NCH*SW-1:0]   in_en;
  logic [N*SW_IN-1:0]  psum_flat;
  logic [N*PW-1:0]     praw_re, praw_im;
  logic signed [OW-1:0] inj_ext;
  logic [N*W-1:0]      zero_in;

  assign zero_in = '0;
  assign inj_ext = OW'(signed'(inj_value));

  genvar gc;
  generate
    for (gc = 0; gc < NCH; gc++) begin : g_ch
      pfg_fft4 #(.IW(W)) i_core (
        .x_flat (in_samples[gc*N*W +: N*W]),
        .re_flat(raw_re[gc*N*OW +: N*OW]),
        .im_flat(raw_im[gc*N*OW +: N*OW])
      );
      pfg_sqsum #(.CW(W), .N(N), .SW(SW)) i_in_energy (
        .re_flat(in_samples[gc*N*W +: N*W]),
        .im_flat(zero_in),
        .energy (in_en[gc*SW +: SW])
      );
    end
  endgenerate

  // Fault injection on bin 1 real part of selected channels.
  always_comb begin
    hit_re = raw_re;
    for (int c = 0; c < NCH; c++) begin
      if (inj_mask[c]) begin
        hit_re[(c*N+1)*OW +: OW] = raw_re[(c*N+1)*OW +: OW] + inj_ext;
      end
    end
  end

  // Point-wise sum of all channel inputs, widened against overflow.
  always_comb begin
    psum_flat = '0;
    for (int k = 0; k < N; k++) begin
      for (int c = 0; c < NCH; c++) begin
        psum_flat[k*SW_IN +: SW_IN] = psum_flat[k*SW_IN +: SW_IN]
          + SW_IN'(signed'(in_samples[(c*N+k)*W +: W]));
      end
    end
  end

  pfg_fft4 #(.IW(SW_IN)) i_parity_core (
    .x_flat (psum_flat),
    .re_flat(praw_re),
    .im_flat(praw_im)
  );

  logic                s1_valid;
  logic [NCH*N*OW-1:0] s1_re, s1_im;
  logic [N*PW-1:0]     s1_pre, s1_pim;
  logic [NCH*SW-1:0]   s1_inen;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_re    <= '0;
      s1_im    <= '0;
      s1_pre   <= '0;
      s1_pim   <= '0;
      s1_inen  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_re    <= hit_re;
      s1_im    <= raw_im;
      s1_pre   <= praw_re;
      s1_pim   <= praw_im;
      s1_inen  <= in_en;
    end
  end

  // ---------------- stage 2: energy compare and rebuild ----------------
  logic [NCH*SW-1:0]   out_en;
  logic [NCH-1:0]      mismatch;
  logic [NCH*N*OW-1:0] fix_re, fix_im;
  logic                multi;

  generate
    for (gc = 0; gc < NCH; gc++) begin : g_chk
      pfg_sqsum #(.CW(OW), .N(N), .SW(SW)) i_out_energy (
        .re_flat(s1_re[gc*N*OW +: N*OW]),
        .im_flat(s1_im[gc*N*OW +: N*OW]),
        .energy (out_en[gc*SW +: SW])
      );
      // Parseval for an unscaled 4-point DFT: output energy = 4 x input energy.
      assign mismatch[gc] = (out_en[gc*SW +: SW] != {s1_inen[gc*SW +: SW-2], 2'b00});
    end
  endgenerate

  pfg_rebuild #(.NCH(NCH), .N(N), .OW(OW), .PW(PW)) i_rebuild (
    .ch_re (s1_re),
    .ch_im (s1_im),
    .par_re(s1_pre),
    .par_im(s1_pim),
    .flags (mismatch),
    .fix_re(fix_re),
    .fix_im(fix_im),
    .multi (multi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_re        <= '0;
      out_im        <= '0;
      err_flags     <= '0;
      uncorrectable <= 1'b0;
    end else begin
      out_valid     <= s1_valid;
      out_re        <= fix_re;
      out_im        <= fix_im;
      err_flags     <= s1_valid ? mismatch : '0;
      uncorrectable <= s1_valid & multi;
    end
  end
endmodule

// File: rtl/pfg_checker.sv
`timescale 1ns/1ps
module pfg_checker #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           out_valid,
  input logic [NCH-1:0] err_flags,
  input logic           uncorrectable
);
  logic v_d1, v_d2;
  always_ff @(posedge clk) begin
    if (rst) begin
      v_d1 <= 1'b0;
      v_d2 <= 1'b0;
    end else begin
      v_d1 <= in_valid;
      v_d2 <= v_d1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && err_flags == '0 && !uncorrectable));

  assert_latency_two_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_d2);

  assert_flags_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (err_flags == '0 && !uncorrectable));

  assert_multi_flag_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (uncorrectable == ($countones(err_flags) > 1)));

  assert_single_ok_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(err_flags) |-> !uncorrectable);
endmodule

bind parity_fft_guard pfg_checker #(.NCH(NCH)) i_pfg_checker (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .out_valid    (out_valid),
  .err_flags    (err_flags),
  .uncorrectable(uncorrectable)
);

// File: tb/test_parity_fft_guard.sv
`timescale 1ns/1ps
module test_parity_fft_guard;
  localparam int NCH = 4;
  localparam int N   = 4;
  localparam int W   = 6;
  localparam int OW  = W + 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                rst, in_valid;
  logic [NCH*N*W-1:0]  in_samples;
  logic [NCH-1:0]      inj_mask;
  logic [W-1:0]        inj_value;
  logic                out_valid;
  logic [NCH*N*OW-1:0] out_re, out_im;
  logic [NCH-1:0]      err_flags;
  logic                uncorrectable;

  parity_fft_guard #(.NCH(NCH), .W(W)) i_parity_fft_guard (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_samples(in_samples),
    .inj_mask(inj_mask), .inj_value(inj_value), .out_valid(out_valid),
    .out_re(out_re), .out_im(out_im), .err_flags(err_flags),
    .uncorrectable(uncorrectable)
  );

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One transaction: drive, confirm nothing early, then check the full result.
  task automatic run_txn(input logic [NCH*N*W-1:0] vec, input logic [NCH-1:0] mask,
                         input int inj, input string tag);
    logic [NCH*N*OW-1:0] exp_re, exp_im;
    int a, b, c, d, nflag;
    int re_k [N];
    int im_k [N];
    string req_data;
    nflag = $countones(mask);
    for (int ch = 0; ch < NCH; ch++) begin
      a = int'(signed'(vec[(ch*N+0)*W +: W]));
      b = int'(signed'(vec[(ch*N+1)*W +: W]));
      c = int'(signed'(vec[(ch*N+2)*W +: W]));
      d = int'(signed'(vec[(ch*N+3)*W +: W]));
      re_k[0] = a + b + c + d; im_k[0] = 0;
      re_k[1] = a - c;         im_k[1] = d - b;
      re_k[2] = a - b + c - d; im_k[2] = 0;
      re_k[3] = a - c;         im_k[3] = b - d;
      // R4/R7: injected error survives only when two or more channels are hit
      if (mask[ch] && nflag > 1) re_k[1] = re_k[1] + inj;
      for (int k = 0; k < N; k++) begin
        exp_re[(ch*N+k)*OW +: OW] = OW'(re_k[k]);
        exp_im[(ch*N+k)*OW +: OW] = OW'(im_k[k]);
      end
    end
    @(negedge clk);
    in_samples = vec;
    inj_mask   = mask;
    inj_value  = W'(inj);
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    inj_mask = '0;
    check(out_valid == 1'b0, "R2", {tag, " valid early"}, 64'(out_valid), 64'd0);
    check(err_flags == '0 && !uncorrectable, "R9", {tag, " flags while idle"},
          64'({uncorrectable, err_flags}), 64'd0);
    @(negedge clk);
    check(out_valid == 1'b1, "R2", {tag, " valid at two cycles"}, 64'(out_valid), 64'd1);
    check(err_flags == mask, "R5", {tag, " flags"}, 64'(err_flags), 64'(mask));
    check(uncorrectable == (nflag > 1), "R7", {tag, " uncorrectable"},
          64'(uncorrectable), 64'(nflag > 1));
    req_data = (nflag == 0) ? "R3" : (nflag == 1) ? "R6" : "R4/R7";
    for (int ch = 0; ch < NCH; ch++) begin
      check({out_re[ch*N*OW +: N*OW], out_im[ch*N*OW +: N*OW]} ==
            {exp_re[ch*N*OW +: N*OW], exp_im[ch*N*OW +: N*OW]},
            req_data, $sformatf("%s spectrum ch%0d", tag, ch),
            64'({out_re[ch*N*OW +: N*OW], out_im[ch*N*OW +: N*OW]}),
            64'({exp_re[ch*N*OW +: N*OW], exp_im[ch*N*OW +: N*OW]}));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [NCH*N*W-1:0] vec;
    rst = 1'b1; in_valid = 1'b1; in_samples = '1; inj_mask = '1; inj_value = 6'd1;
    repeat (4) @(negedge clk);
    // R1: reset holds everything at zero even with a strobe present
    check(!out_valid && err_flags == '0 && !uncorrectable, "R1", "status in reset",
          64'({out_valid, uncorrectable, err_flags}), 64'd0);
    check(out_re == '0 && out_im == '0, "R1", "spectra in reset",
          64'(out_re ^ out_im), 64'd0);
    in_valid = 1'b0; inj_mask = '0;
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid, "R1", "valid after reset", 64'(out_valid), 64'd0);

    // R3/R4/R5/R6/R7 sweep: every injection mask, many patterns, odd offsets
    for (int t = 0; t < 1024; t++) begin
      for (int ch = 0; ch < NCH; ch++)
        for (int n = 0; n < N; n++)
          vec[(ch*N+n)*W +: W] = W'(((t*7 + ch*13 + n*29 + (t>>3)*ch) % 64) - 32);
      run_txn(vec, NCH'(t % 16), ((t >> 4) % 8) * 2 + 1 - ((t >> 7) % 2) * 16,
              $sformatf("sweep%0d", t));
    end

    // R8: full-scale inputs through the widened parity path
    for (int m = 0; m < NCH; m++) begin
      vec = {NCH*N{6'b100000}};
      run_txn(vec, NCH'(1 << m), 1, $sformatf("R8 min ch%0d", m));
      vec = {NCH*N{6'b011111}};
      run_txn(vec, NCH'(1 << m), -1, $sformatf("R8 max ch%0d", m));
    end
    vec = {NCH*N{6'b100000}};
    run_txn(vec, '0, 1, "R8 min clean");

    // R2: back-to-back strobes yield back-to-back results
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b1, "R2", "burst first", 64'(out_valid), 64'd1);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b1, "R2", "burst second", 64'(out_valid), 64'd1);
    @(negedge clk);
    check(out_valid == 1'b0, "R2", "burst end", 64'(out_valid), 64'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule